// File: doc/BRIEF.md
# Video Memory Host Access Port

This block lets a host processor reach a 32K-word, 16-bit video memory through a few byte-wide registers. The host sets a word address with two byte writes, stores data one byte lane at a time, and reads data back through a pair of byte registers fed from a read-ahead latch. A single mode register picks which byte access advances the address, how far it moves, and whether the address is bit-rotated before it reaches the memory. This bit rotation lets bitplane rows of 8, 9 or 10 bits be stored next to each other.

The memory sits outside the block on a simple synchronous port. A write happens in the same cycle as the host's data strobe. A read is issued one cycle after the address changes, and its result lands in the latch one cycle after that. The host must leave at least three idle cycles between accesses.

Host register selects: 0 = mode, 1 = address low byte, 2 = address high byte, 3 = data low byte, 4 = data high byte. Reads at select 4 return the high byte of the latch. Reads at any other select return the low byte.

Top module: `vram_port`

## Requirements
- R1: After reset the word address is 0, the read latch is 0, the mode is all zero, and neither memory strobe is active.
- R2: A write to select 1 loads address bits 7:0. A write to select 2 loads address bits 14:8 from data bits 6:0, and data bit 7 is ignored. The address does not change in a cycle with no host access.
- R3: A write to select 3 asserts a memory write with byte enables 01. A write to select 4 asserts one with byte enables 10. In both cases the host byte appears on both lanes of the write data. No other access writes memory, and at most one lane is ever enabled.
- R4: Mode bit 7 = 0 advances the address after a low-byte data access (select 3). Mode bit 7 = 1 advances it after a high-byte data access (select 4).
- R5: Mode bits 1:0 set the step: 00 = 1 word, 01 = 32 words, 10 or 11 = 128 words. The address wraps modulo 32K.
- R6: Mode bits 3:2 choose the remap applied to the memory address: 00 = none; 01, 10 and 11 rotate the low 8, 9 or 10 address bits left by 3. Upper bits pass through unchanged, and the internal address counts without remapping.
- R7: After an address write or an advance, the block issues a memory read at the new remapped address in the next cycle. The result is loaded into the latch, and data reads return bytes of that latch.
- R8: Data reads advance the address under the same mode rules as data writes.
- R9: A data access that does not advance the address issues no memory read and leaves the latch unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWr | input | 1 | Host register write strobe |
| hostRd | input | 1 | Host register read strobe |
| hostSel | input | 3 | Host register select |
| hostWdata | input | 8 | Host write byte |
| hostRdata | output | 8 | Host read byte from the latch |
| memAddr | output | 15 | Memory word address (remapped) |
| memWrEn | output | 1 | Memory write enable |
| memByteEn | output | 2 | Memory byte-lane enables {high, low} |
| memWrData | output | 16 | Memory write data |
| memRdEn | output | 1 | Memory read enable |
| memRdData | input | 16 | Memory read data, one cycle after memRdEn |

## Verification
The bench uses the default parameters: a 15-bit address, steps of 32 and 128, and remap rotation by 3 over base width 8. With these values, a step from address 0x7FFF wraps to zero, and all three rotation widths can be told apart by their write addresses. The reference model keeps its own memory image. A fault in remapping, stepping or lane selection therefore shows up as wrong data on later reads, as well as through the direct address checks.

// File: rtl/vram_port_pkg.sv
package vram_port_pkg;

  typedef enum logic [2:0] {
    SEL_MODE    = 3'd0,
    SEL_ADDR_LO = 3'd1,
    SEL_ADDR_HI = 3'd2,
    SEL_DATA_LO = 3'd3,
    SEL_DATA_HI = 3'd4
  } regSel_e;

  typedef struct packed {
    logic loadMode;
    logic loadAddrLo;
    logic loadAddrHi;
    logic writeLo;
    logic writeHi;
    logic advance;
    logic fetch;
    logic capture;
  } ctrlStrobes_t;

endpackage

// File: rtl/vram_port_ctrl.sv
module vram_port_ctrl
  import vram_port_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         hostWr,
  input  logic         hostRd,
  input  logic [2:0]   hostSel,
  input  logic         incOnHigh,
  output ctrlStrobes_t stb
);

  logic isDataLo;
  logic isDataHi;
  logic access;
  logic advanceNow;
  logic addrLoad;
  logic fetchPend;
  logic capPend;

  always_comb begin
    isDataLo   = (hostSel == SEL_DATA_LO);
    isDataHi   = (hostSel == SEL_DATA_HI);
    access     = hostWr | hostRd;
    advanceNow = access && (incOnHigh ? isDataHi : isDataLo);
    addrLoad   = hostWr && ((hostSel == SEL_ADDR_LO) || (hostSel == SEL_ADDR_HI));
  end

  // read-ahead pipeline: issue one cycle after the address moves, capture one later
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fetchPend <= 1'b0;
      capPend   <= 1'b0;
    end else begin
      fetchPend <= addrLoad | advanceNow;
      capPend   <= fetchPend;
    end
  end

  always_comb begin
    stb.loadMode   = hostWr && (hostSel == SEL_MODE);
    stb.loadAddrLo = hostWr && (hostSel == SEL_ADDR_LO);
    stb.loadAddrHi = hostWr && (hostSel == SEL_ADDR_HI);
    stb.writeLo    = hostWr && isDataLo;
    stb.writeHi    = hostWr && isDataHi;
    stb.advance    = advanceNow;
    stb.fetch      = fetchPend;
    stb.capture    = capPend;
  end

endmodule

// File: rtl/vram_port_dp.sv
module vram_port_dp
  import vram_port_pkg::*;
#(
  parameter int ADDR_W     = 15,
  parameter int STEP_MID   = 32,
  parameter int STEP_BIG   = 128,
  parameter int REMAP_BASE = 8,
  parameter int REMAP_ROT  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      stb,
  input  logic [7:0]        hostWdata,
  input  logic [15:0]       memRdData,
  output logic              incOnHigh,
  output logic [1:0]        remapSel,
  output logic [ADDR_W-1:0] wordAddr,
  output logic [15:0]       rdLatch,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWrEn,
  output logic [1:0]        memByteEn,
  output logic [15:0]       memWrData,
  output logic              memRdEn
);

  localparam int HI_W = ADDR_W - 8;
  localparam logic [ADDR_W-1:0] STEP_ONE_V = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] STEP_MID_V = ADDR_W'(STEP_MID);
  localparam logic [ADDR_W-1:0] STEP_BIG_V = ADDR_W'(STEP_BIG);
  localparam int NUM_MAPS = 4;

  logic [1:0]        stepSel;
  logic [ADDR_W-1:0] stepVal;
  logic [ADDR_W-1:0] remapOpt [NUM_MAPS];

  // mode register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      incOnHigh <= 1'b0;
      remapSel  <= 2'd0;
      stepSel   <= 2'd0;
    end else if (stb.loadMode) begin
      incOnHigh <= hostWdata[7];
      remapSel  <= hostWdata[3:2];
      stepSel   <= hostWdata[1:0];
    end
  end

  always_comb begin
    case (stepSel)
      2'd0:    stepVal = STEP_ONE_V;
      2'd1:    stepVal = STEP_MID_V;
      default: stepVal = STEP_BIG_V;
    endcase
  end

  // linear word address counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordAddr <= '0;
    end else if (stb.loadAddrLo) begin
      wordAddr[7:0] <= hostWdata;
    end else if (stb.loadAddrHi) begin
      wordAddr[ADDR_W-1:8] <= hostWdata[HI_W-1:0];
    end else if (stb.advance) begin
      wordAddr <= wordAddr + stepVal;
    end
  end

  // remap variants: rotate the low N bits left, N growing by one per mode
  assign remapOpt[0] = wordAddr;
  for (genvar k = 1; k < NUM_MAPS; k++) begin : g_remap
    localparam int N = REMAP_BASE + k - 1;
    assign remapOpt[k] = {wordAddr[ADDR_W-1:N],
                          wordAddr[N-REMAP_ROT-1:0],
                          wordAddr[N-1:N-REMAP_ROT]};
  end

  assign memAddr   = remapOpt[remapSel];
  assign memWrEn   = stb.writeLo | stb.writeHi;
  assign memByteEn = {stb.writeHi, stb.writeLo};
  assign memWrData = {hostWdata, hostWdata};
  assign memRdEn   = stb.fetch;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdLatch <= '0;
    end else if (stb.capture) begin
      rdLatch <= memRdData;
    end
  end

endmodule

// File: rtl/vram_port.sv
module vram_port
  import vram_port_pkg::*;
#(
  parameter int ADDR_W     = 15,
  parameter int STEP_MID   = 32,
  parameter int STEP_BIG   = 128,
  parameter int REMAP_BASE = 8,
  parameter int REMAP_ROT  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [2:0]        hostSel,
  input  logic [7:0]        hostWdata,
  output logic [7:0]        hostRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWrEn,
  output logic [1:0]        memByteEn,
  output logic [15:0]       memWrData,
  output logic              memRdEn,
  input  logic [15:0]       memRdData
);

  ctrlStrobes_t      stb;
  logic              incOnHigh;
  logic [1:0]        curRemap;
  logic [ADDR_W-1:0] curAddr;
  logic [15:0]       rdLatch;

  vram_port_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .hostWr    (hostWr),
    .hostRd    (hostRd),
    .hostSel   (hostSel),
    .incOnHigh (incOnHigh),
    .stb       (stb)
  );

  vram_port_dp #(
    .ADDR_W     (ADDR_W),
    .STEP_MID   (STEP_MID),
    .STEP_BIG   (STEP_BIG),
    .REMAP_BASE (REMAP_BASE),
    .REMAP_ROT  (REMAP_ROT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .hostWdata (hostWdata),
    .memRdData (memRdData),
    .incOnHigh (incOnHigh),
    .remapSel  (curRemap),
    .wordAddr  (curAddr),
    .rdLatch   (rdLatch),
    .memAddr   (memAddr),
    .memWrEn   (memWrEn),
    .memByteEn (memByteEn),
    .memWrData (memWrData),
    .memRdEn   (memRdEn)
  );

  assign hostRdata = (hostSel == SEL_DATA_HI) ? rdLatch[15:8] : rdLatch[7:0];

endmodule

// File: rtl/vram_port_chk.sv
module vram_port_chk #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostWr,
  input logic              hostRd,
  input logic [2:0]        hostSel,
  input logic              memWrEn,
  input logic              memRdEn,
  input logic [1:0]        memByteEn,
  input logic [ADDR_W-1:0] memAddr,
  input logic [ADDR_W-1:0] curAddr,
  input logic [1:0]        curRemap
);

  assert_write_from_host_R3: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> (hostWr && (hostSel == 3'd3 || hostSel == 3'd4)));

  assert_single_lane_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(memByteEn) && (memWrEn == (memByteEn != 2'b00)));

  assert_fetch_after_access_R7: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> $past(hostWr || hostRd));

  assert_addr_idle_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!hostWr && !hostRd) |=> $stable(curAddr));

  assert_plain_map_R6: assert property (@(posedge clk) disable iff (!rstN)
    (curRemap == 2'd0) |-> (memAddr == curAddr));

endmodule

bind vram_port vram_port_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .hostWr    (hostWr),
  .hostRd    (hostRd),
  .hostSel   (hostSel),
  .memWrEn   (memWrEn),
  .memRdEn   (memRdEn),
  .memByteEn (memByteEn),
  .memAddr   (memAddr),
  .curAddr   (curAddr),
  .curRemap  (curRemap)
);

// File: tb/sim_vram_port.sv
`timescale 1ns/1ps
module sim_vram_port;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWr = 1'b0;
  logic        hostRd = 1'b0;
  logic [2:0]  hostSel = 3'd3;
  logic [7:0]  hostWdata = 8'd0;
  logic [7:0]  hostRdata;
  logic [14:0] memAddr;
  logic        memWrEn;
  logic [1:0]  memByteEn;
  logic [15:0] memWrData;
  logic        memRdEn;
  logic [15:0] memRdData = 16'd0;

  int nTests = 0;
  int nFail  = 0;
  bit settled = 1'b0;
  bit done = 1'b0;

  // reference model state
  int          refAddr = 0;
  logic [7:0]  refMode = 8'd0;
  logic [15:0] refLatch = 16'd0;
  logic [15:0] refMem [int];
  logic [15:0] vmem [int];
  logic [15:0] wtmp;

  always #10 clk = ~clk;

  vram_port u0 (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostRd(hostRd),
    .hostSel(hostSel), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .memAddr(memAddr), .memWrEn(memWrEn), .memByteEn(memByteEn),
    .memWrData(memWrData), .memRdEn(memRdEn), .memRdData(memRdData)
  );

  // synchronous memory with one cycle read latency
  always @(posedge clk) begin
    if (memWrEn) begin
      wtmp = vmem.exists(int'(memAddr)) ? vmem[int'(memAddr)] : 16'd0;
      if (memByteEn[0]) wtmp[7:0]  = memWrData[7:0];
      if (memByteEn[1]) wtmp[15:8] = memWrData[15:8];
      vmem[int'(memAddr)] = wtmp;
    end
    if (memRdEn)
      memRdData <= vmem.exists(int'(memAddr)) ? vmem[int'(memAddr)] : 16'd0;
  end

  function automatic int remapF(int a, logic [7:0] m);
    int n, mask, low;
    if (m[3:2] == 2'd0) return a;
    n = 7 + int'(m[3:2]);
    mask = (1 << n) - 1;
    low = a & mask;
    return (a & ~mask) | (((low << 3) | (low >> (n - 3))) & mask);
  endfunction

  function automatic int stepF(logic [7:0] m);
    if (m[1:0] == 2'd0) return 1;
    if (m[1:0] == 2'd1) return 32;
    return 128;
  endfunction

  function automatic logic [15:0] refRead(int a);
    return refMem.exists(a) ? refMem[a] : 16'd0;
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    nTests++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, got, exp, $time);
    end
  endtask

  // per-clock comparison against the model while no access is in flight
  always @(negedge clk) begin
    #5;
    if (settled && rstN && !done) begin
      check("R7 read byte", {24'd0, hostRdata},
            {24'd0, (hostSel == 3'd4) ? refLatch[15:8] : refLatch[7:0]});
      check("R9 idle strobes", {30'd0, memWrEn, memRdEn}, 32'd0);
    end
  end

  task automatic hostOp(input bit wr, input logic [2:0] sel, input logic [7:0] d);
    bit fetch;
    bit isData;
    bit adv;
    int phys;
    logic [15:0] w;
    @(negedge clk);
    settled = 1'b0;
    hostWr = wr; hostRd = !wr; hostSel = sel; hostWdata = d;
    #2;
    phys = remapF(refAddr, refMode);
    isData = (sel == 3'd3) || (sel == 3'd4);
    if (wr && isData) begin
      check("R3 write strobe", {31'd0, memWrEn}, 32'd1);
      check("R3 byte lanes", {30'd0, memByteEn}, (sel == 3'd4) ? 32'd2 : 32'd1);
      check("R3 lane data", {16'd0, memWrData}, {16'd0, d, d});
      check("R6 write address", {17'd0, memAddr}, phys);
    end else begin
      check("R3 no write", {31'd0, memWrEn}, 32'd0);
    end
    if (!wr && isData)
      check("R7 read value", {24'd0, hostRdata},
            {24'd0, (sel == 3'd4) ? refLatch[15:8] : refLatch[7:0]});
    // model update
    fetch = 1'b0;
    adv = isData && (refMode[7] ? (sel == 3'd4) : (sel == 3'd3));
    if (wr) begin
      case (sel)
        3'd0: refMode = d;
        3'd1: begin refAddr = (refAddr & 32'h7F00) | int'(d); fetch = 1'b1; end
        3'd2: begin refAddr = ((int'(d) & 32'h7F) << 8) | (refAddr & 32'hFF); fetch = 1'b1; end
        3'd3: begin w = refRead(phys); w[7:0] = d; refMem[phys] = w; end
        3'd4: begin w = refRead(phys); w[15:8] = d; refMem[phys] = w; end
        default: ;
      endcase
    end
    if (adv) begin
      refAddr = (refAddr + stepF(refMode)) & 32'h7FFF;
      fetch = 1'b1;
    end
    @(negedge clk);
    hostWr = 1'b0; hostRd = 1'b0;
    #2;
    if (fetch) begin
      check("R7 read issued", {31'd0, memRdEn}, 32'd1);
      check("R7 read address", {17'd0, memAddr}, remapF(refAddr, refMode));
    end else begin
      check("R9 no read issued", {31'd0, memRdEn}, 32'd0);
    end
    @(negedge clk);
    @(negedge clk);
    if (fetch) refLatch = refRead(remapF(refAddr, refMode));
    settled = 1'b1;
  endtask

  task automatic setAddr(input int a);
    hostOp(1'b1, 3'd1, a[7:0]);
    hostOp(1'b1, 3'd2, a[15:8]);
  endtask

  task automatic writeWord(input logic [15:0] v);
    hostOp(1'b1, 3'd3, v[7:0]);
    hostOp(1'b1, 3'd4, v[15:8]);
  endtask

  task automatic readWord(input string req, input logic [15:0] exp);
    logic [15:0] got;
    @(negedge clk);
    hostSel = 3'd3; #3; got[7:0] = hostRdata;
    hostSel = 3'd4; #3; got[15:8] = hostRdata;
    check(req, {16'd0, got}, {16'd0, exp});
    hostOp(1'b0, 3'd3, 8'd0);
    hostOp(1'b0, 3'd4, 8'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #2;
    // R1: reset state
    hostSel = 3'd3; #1; check("R1 latch low", {24'd0, hostRdata}, 32'd0);
    hostSel = 3'd4; #1; check("R1 latch high", {24'd0, hostRdata}, 32'd0);
    check("R1 strobes", {30'd0, memWrEn, memRdEn}, 32'd0);
    check("R1 address", {17'd0, memAddr}, 32'd0);
    settled = 1'b1;

    // R2 R4: high-byte advance, top bit of address high byte ignored
    hostOp(1'b1, 3'd0, 8'h80);
    hostOp(1'b1, 3'd1, 8'h10);
    hostOp(1'b1, 3'd2, 8'h80);
    writeWord(16'h1234);
    writeWord(16'h5678);
    writeWord(16'h9ABC);
    setAddr(16'h0010);
    readWord("R8 readback word0", 16'h1234);
    readWord("R8 readback word1", 16'h5678);
    readWord("R8 readback word2", 16'h9ABC);

    // R4: low-byte advance mode, write high then low
    hostOp(1'b1, 3'd0, 8'h00);
    setAddr(16'h0100);
    hostOp(1'b1, 3'd4, 8'hDE);
    hostOp(1'b1, 3'd3, 8'hAD);
    hostOp(1'b1, 3'd4, 8'hBE);
    hostOp(1'b1, 3'd3, 8'hEF);
    hostOp(1'b1, 3'd0, 8'h80);
    setAddr(16'h0100);
    readWord("R4 low-advance word0", 16'hDEAD);
    readWord("R4 low-advance word1", 16'hBEEF);

    // R9: non-advancing reads leave latch alone
    setAddr(16'h0010);
    hostOp(1'b0, 3'd3, 8'd0);
    hostOp(1'b0, 3'd3, 8'd0);
    readWord("R9 latch unchanged", 16'h1234);

    // R5: step sizes
    hostOp(1'b1, 3'd0, 8'h81);
    setAddr(16'h0200);
    writeWord(16'hA001);
    writeWord(16'hA002);
    hostOp(1'b1, 3'd0, 8'h82);
    writeWord(16'hA003);
    hostOp(1'b1, 3'd0, 8'h83);
    writeWord(16'hA004);
    hostOp(1'b1, 3'd0, 8'h80);
    setAddr(16'h0220);
    readWord("R5 step 32", 16'hA002);
    setAddr(16'h0240);
    readWord("R5 step 32 again", 16'hA003);
    setAddr(16'h02C0);
    readWord("R5 step 128", 16'hA004);

    // R5: wrap at top of address space
    setAddr(16'h7FFF);
    writeWord(16'h7E57);
    readWord("R5 wrap to zero", 16'h0000);
    setAddr(16'h7FFF);
    readWord("R5 last word", 16'h7E57);

    // R6: remap modes
    hostOp(1'b1, 3'd0, 8'h84);
    setAddr(16'h0321);
    writeWord(16'hC0DE);
    hostOp(1'b1, 3'd0, 8'h88);
    setAddr(16'h0521);
    writeWord(16'hC1DE);
    hostOp(1'b1, 3'd0, 8'h8C);
    setAddr(16'h07A5);
    writeWord(16'hC2DE);
    hostOp(1'b1, 3'd0, 8'h80);
    setAddr(16'h0309);
    readWord("R6 rotate 8", 16'hC0DE);
    setAddr(remapF(16'h0521, 8'h08));
    readWord("R6 rotate 9", 16'hC1DE);
    setAddr(remapF(16'h07A5, 8'h0C));
    readWord("R6 rotate 10", 16'hC2DE);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule